// File: doc/BRIEF.md
# Sample Threshold Comparator with Match Counter

This block watches a stream of 16-bit samples, one per strobe. It checks each sample against a programmable reference value, using either a below-reference test or an at-or-above-reference test. It counts the samples that satisfy the test. Once the count reaches a programmable target, it raises a sticky flag. The flag stays up until software writes a one to it. An interrupt request follows the flag when interrupts are enabled.

The control fields are loaded together through one write strobe:

- enable
- condition select
- 4-bit match-count setting
- interrupt enable
- reference value

The flag has its own write strobe and data bit. A design that needs several independent thresholds places several instances side by side.

Top module: `sample_threshold_cmp`

## Requirements
- R1: After reset, `hit_flag` and `irq` are 0, and the configuration is all zeros, so comparison is off.
- R2: A cycle with `cfg_wr` high loads every control field at that clock edge. Samples strobed in later cycles use the new settings.
- R3: With `cfg_cond_ge` = 0, a sample matches when it is strictly less than `cfg_ref`, compared as unsigned numbers. A sample equal to the reference does not match.
- R4: With `cfg_cond_ge` = 1, a sample matches when it is greater than or equal to `cfg_ref`, compared as unsigned numbers.
- R5: Each matching sample with `smp_valid` = 1 adds one to the internal counter. A non-matching sample, or a cycle with `smp_valid` = 0, leaves the counter unchanged. `hit_flag` rises at the clock edge that takes the match bringing the counter to `cfg_count` + 1.
- R6: `hit_flag` is sticky. A cycle with `clr_wr` = 1 and `clr_data` = 1 clears the flag and zeroes the counter. When `clr_data` = 0, the write has no effect.
- R7: While compare is disabled, samples are ignored and the counter is held at zero. The flag is left as it was.
- R8: `irq` is 1 exactly when `hit_flag` is 1 and the interrupt-enable field is 1.
- R9: A clear write and a match in the same cycle restart the count from zero and include that match. If that match alone reaches the target, the flag stays set, because the set wins over the clear.
- R10: While the flag is set, further matches do not advance the counter. After a clear, a full `cfg_count` + 1 new matches are needed to set the flag again.
- R11: If the count setting is lowered below the current counter value, the next match sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Strobe marking a new sample on `smp_data` |
| smp_data | input | 16 | Sample word |
| cfg_wr | input | 1 | Loads all control fields |
| cfg_enable | input | 1 | Compare enable field |
| cfg_cond_ge | input | 1 | Condition select: 0 means below, 1 means at or above |
| cfg_count | input | 4 | Match-count setting; the flag is set after this value plus one matches |
| cfg_irq_en | input | 1 | Interrupt enable field |
| cfg_ref | input | 16 | Reference value |
| clr_wr | input | 1 | Write strobe for the flag |
| clr_data | input | 1 | Data bit written to the flag; a 1 clears it |
| hit_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |

## Verification
The counter cannot be seen directly. A wrong count shows only as `hit_flag` rising one or more samples early or late. The bench therefore checks the flag after every cycle, so an error is reported on the first sample where the flag is wrong.

Several cases only reveal a stale counter on a later pass:

- a counter that is not zeroed on a clear or a disable;
- a counter that keeps running while the flag is up;
- a counter compared for equality rather than reaching the target.

Each of these shows up as an early flag on the next counting run. The bench counts out a full run after each clear, each disable and each lowering of the count setting for this reason.

// File: rtl/stc_pkg.sv
package stc_pkg;

    // Condition select encoding
    typedef enum logic {
        COND_BELOW   = 1'b0,
        COND_AT_ABOVE = 1'b1
    } cmp_cond_e;

endpackage

// File: rtl/stc_cfg_reg.sv
module stc_cfg_reg
    import stc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              enable_i,
    input  logic              cond_ge_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              irq_en_i,
    input  logic [DATA_W-1:0] ref_i,
    output logic              enable_o,
    output cmp_cond_e         cond_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              irq_en_o,
    output logic [DATA_W-1:0] ref_o
);

    typedef struct packed {
        logic              enable;
        cmp_cond_e         cond;
        logic [CNT_W-1:0]  count;
        logic              irq_en;
        logic [DATA_W-1:0] refv;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.enable = enable_i;
            cfg_d.cond   = cmp_cond_e'(cond_ge_i);
            cfg_d.count  = count_i;
            cfg_d.irq_en = irq_en_i;
            cfg_d.refv   = ref_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{enable: 1'b0, cond: COND_BELOW, count: '0, irq_en: 1'b0, refv: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign enable_o = cfg_q.enable;
    assign cond_o   = cfg_q.cond;
    assign count_o  = cfg_q.count;
    assign irq_en_o = cfg_q.irq_en;
    assign ref_o    = cfg_q.refv;

endmodule

// File: rtl/stc_compare.sv
module stc_compare
    import stc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              valid,
    input  logic              enable,
    input  cmp_cond_e         cond,
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] refv,
    output logic              hit
);

    logic below;

    always_comb begin
        below = (sample < refv);
        unique case (cond)
            COND_BELOW:    hit = valid && enable && below;
            COND_AT_ABOVE: hit = valid && enable && !below;
            default:       hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/stc_match_ctr.sv
module stc_match_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             hit,
    input  logic             clr,
    input  logic [CNT_W-1:0] count_set,
    output logic             flag
);

    localparam int TALLY_W = CNT_W + 1;

    typedef struct packed {
        logic [TALLY_W-1:0] tally;
        logic               flag;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [TALLY_W-1:0] target;
    logic [TALLY_W-1:0] base;
    logic [TALLY_W-1:0] bumped;

    always_comb begin
        target = {1'b0, count_set} + TALLY_W'(1);
        base   = clr ? '0 : ctr_q.tally;
        bumped = base + TALLY_W'(1);
        ctr_d       = ctr_q;
        ctr_d.tally = base;
        if (clr) begin
            ctr_d.flag = 1'b0;
        end
        if (!enable) begin
            ctr_d.tally = '0;
        end else if (hit && (!ctr_q.flag || clr)) begin
            ctr_d.tally = bumped;
            if (bumped >= target) begin
                ctr_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '{tally: '0, flag: 1'b0};
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign flag = ctr_q.flag;

endmodule

// File: rtl/sample_threshold_cmp.sv
module sample_threshold_cmp
    import stc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              cfg_wr,
    input  logic              cfg_enable,
    input  logic              cfg_cond_ge,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_irq_en,
    input  logic [DATA_W-1:0] cfg_ref,
    input  logic              clr_wr,
    input  logic              clr_data,
    output logic              hit_flag,
    output logic              irq
);

    logic              en_q;
    cmp_cond_e         cond_q;
    logic [CNT_W-1:0]  count_q;
    logic              irq_en_q;
    logic [DATA_W-1:0] ref_q;
    logic              hit;
    logic              clr_req;

    stc_cfg_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .enable_i  (cfg_enable),
        .cond_ge_i (cfg_cond_ge),
        .count_i   (cfg_count),
        .irq_en_i  (cfg_irq_en),
        .ref_i     (cfg_ref),
        .enable_o  (en_q),
        .cond_o    (cond_q),
        .count_o   (count_q),
        .irq_en_o  (irq_en_q),
        .ref_o     (ref_q)
    );

    stc_compare #(.DATA_W(DATA_W)) u_cmp (
        .valid  (smp_valid),
        .enable (en_q),
        .cond   (cond_q),
        .sample (smp_data),
        .refv   (ref_q),
        .hit    (hit)
    );

    assign clr_req = clr_wr && clr_data;

    stc_match_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (en_q),
        .hit       (hit),
        .clr       (clr_req),
        .count_set (count_q),
        .flag      (hit_flag)
    );

    assign irq = hit_flag && irq_en_q;

endmodule

// File: rtl/stc_checker.sv
module stc_checker (
    input logic clk,
    input logic rst_n,
    input logic smp_valid,
    input logic clr_wr,
    input logic clr_data,
    input logic cmp_en,
    input logic hit_flag,
    input logic irq
);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> hit_flag);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_flag && !(clr_wr && clr_data)) |=> hit_flag);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data && !smp_valid) |=> !hit_flag);

    // R5
    flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_flag) |-> $past(smp_valid));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !hit_flag) |=> !hit_flag);

endmodule

bind sample_threshold_cmp stc_checker u_stc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .cmp_en   (en_q),
    .hit_flag (hit_flag),
    .irq      (irq)
);

// File: tb/test_sample_threshold_cmp.sv
module test_sample_threshold_cmp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_cond_ge = 1'b0;
    logic [3:0]  cfg_count = '0;
    logic        cfg_irq_en = 1'b0;
    logic [15:0] cfg_ref = '0;
    logic        clr_wr = 1'b0;
    logic        clr_data = 1'b0;
    logic        hit_flag;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  flag;
        logic  irq;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    sample_threshold_cmp i_sample_threshold_cmp (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_wr(cfg_wr), .cfg_enable(cfg_enable), .cfg_cond_ge(cfg_cond_ge),
        .cfg_count(cfg_count), .cfg_irq_en(cfg_irq_en), .cfg_ref(cfg_ref),
        .clr_wr(clr_wr), .clr_data(clr_data), .hit_flag(hit_flag), .irq(irq)
    );

    // Monitor: compare outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (hit_flag !== e.flag || irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s: flag/irq actual=%b%b expected=%b%b",
                             e.tag, hit_flag, irq, e.flag, e.irq);
                end
            end
        end
    end

    task automatic push(input logic f, input logic i, input string tag);
        exp_t e;
        e.flag = f; e.irq = i; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic cyc(input logic v, input logic [15:0] d, input logic cw, input logic cd,
                       input logic ef, input logic ei, input string tag);
        @(negedge clk);
        smp_valid = v; smp_data = d; clr_wr = cw; clr_data = cd; cfg_wr = 1'b0;
        @(posedge clk);
        #1;
        push(ef, ei, tag);
    endtask

    task automatic cfg(input logic en, input logic ge, input logic [3:0] cnt, input logic ie,
                       input logic [15:0] rv, input logic ef, input logic ei, input string tag);
        @(negedge clk);
        smp_valid = 1'b0; clr_wr = 1'b0; clr_data = 1'b0;
        cfg_wr = 1'b1; cfg_enable = en; cfg_cond_ge = ge; cfg_count = cnt;
        cfg_irq_en = ie; cfg_ref = rv;
        @(posedge clk);
        #1;
        push(ef, ei, tag);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (hit_flag !== 1'b0 || irq !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset flag/irq actual=%b%b expected=00", hit_flag, irq);
        end
        // R1: reset config is disabled, any sample ignored
        cyc(1, 16'h0000, 0, 0, 0, 0, "R1");

        // R2, R3: below 100, count setting 0
        cfg(1, 0, 4'd0, 1, 16'd100, 0, 0, "R2");
        cyc(1, 16'd200, 0, 0, 0, 0, "R3");
        cyc(1, 16'd100, 0, 0, 0, 0, "R3");
        cyc(1, 16'd99, 0, 0, 1, 1, "R3");
        cyc(1, 16'd5, 0, 0, 1, 1, "R6");
        cyc(0, 16'd0, 1, 0, 1, 1, "R6");
        cyc(0, 16'd0, 1, 1, 0, 0, "R6");

        // R4, R5: at-or-above 0x8000, three matches needed, irq off
        cfg(1, 1, 4'd2, 0, 16'h8000, 0, 0, "R2");
        cyc(1, 16'h7FFF, 0, 0, 0, 0, "R4");
        cyc(1, 16'h8000, 0, 0, 0, 0, "R4");
        cyc(1, 16'h0001, 0, 0, 0, 0, "R5");
        cyc(0, 16'hFFFF, 0, 0, 0, 0, "R5");
        cyc(1, 16'hFFFF, 0, 0, 0, 0, "R5");
        cyc(1, 16'h9000, 0, 0, 1, 0, "R5");
        cfg(1, 1, 4'd2, 1, 16'h8000, 1, 1, "R8");

        // R10: saturation while flagged, full recount after clear
        cyc(1, 16'hA000, 0, 0, 1, 1, "R10");
        cyc(1, 16'hA000, 0, 0, 1, 1, "R10");
        cyc(1, 16'hA000, 0, 0, 1, 1, "R10");
        cyc(0, 16'h0000, 1, 1, 0, 0, "R10");
        cyc(1, 16'hA000, 0, 0, 0, 0, "R10");
        cyc(1, 16'hA000, 0, 0, 0, 0, "R10");
        cyc(1, 16'hA000, 0, 0, 1, 1, "R10");

        // R9: clear and setting match in same cycle
        cfg(1, 1, 4'd0, 1, 16'h8000, 1, 1, "R2");
        cyc(1, 16'hFFFF, 1, 1, 1, 1, "R9");
        cyc(1, 16'h0010, 1, 1, 0, 0, "R9");

        // R7: disable ignores samples and zeroes the counter
        cfg(0, 1, 4'd0, 1, 16'h8000, 0, 0, "R7");
        cyc(1, 16'hFFFF, 0, 0, 0, 0, "R7");
        cfg(1, 1, 4'd0, 1, 16'h8000, 0, 0, "R7");
        cyc(1, 16'hFFFF, 0, 0, 1, 1, "R7");
        cfg(1, 1, 4'd1, 1, 16'h8000, 1, 1, "R2");
        cyc(0, 16'h0000, 1, 1, 0, 0, "R6");
        cyc(1, 16'hFFFF, 0, 0, 0, 0, "R7");
        cfg(0, 1, 4'd1, 1, 16'h8000, 0, 0, "R7");
        cfg(1, 1, 4'd1, 1, 16'h8000, 0, 0, "R7");
        cyc(1, 16'hFFFF, 0, 0, 0, 0, "R7");
        cyc(1, 16'hFFFF, 0, 0, 1, 1, "R7");

        // R11: lowering the count setting below the counter
        cyc(0, 16'h0000, 1, 1, 0, 0, "R6");
        cfg(1, 1, 4'd3, 1, 16'h8000, 0, 0, "R11");
        cyc(1, 16'hC000, 0, 0, 0, 0, "R11");
        cyc(1, 16'hC000, 0, 0, 0, 0, "R11");
        cyc(1, 16'hC000, 0, 0, 0, 0, "R11");
        cfg(1, 1, 4'd1, 1, 16'h8000, 0, 0, "R11");
        cyc(1, 16'hC000, 0, 0, 1, 1, "R11");

        @(negedge clk);
        smp_valid = 1'b0; clr_wr = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule